// File: doc/BRIEF.md
# Chained DMA Destination Tag Reader

This block sits on the receiving end of a chained DMA link. It reads a stream of 32-bit words from a show-ahead FIFO. The stream is a series of destination tags of four words each. Each tag gives a 24-bit destination byte address and a payload length in words. That payload then follows in the same stream. The block writes every payload word to a memory write port and steps the address by four bytes for each word.

Each tag also says whether the chain stops after its payload. A transfer begins with a one-cycle `start` pulse. `busy` stays high while tags and payloads are consumed. When the last payload has drained and the stop condition is met, `busy` drops and a countdown begins. The countdown length is derived from the number of payload words moved. When it expires, a one-cycle interrupt fires and the transfer-in-progress flag is cleared.

Top module: `dmaTagReader`

## Requirements
- R1: After reset, `busy`, `xferFlag`, `irq`, `memWe` and `fifoPop` are all 0.
- R2: A `start` pulse while `xferFlag` is 0 sets `busy` and `xferFlag` on the next cycle. A `start` while a transfer is running has no effect on the writes or on completion.
- R3: A tag is read only when the remaining word count is zero, no stop is pending and `fifoCount` is at least 4. Reading a tag pops exactly four words on four consecutive cycles. While a tag is awaited with fewer than 4 words present, nothing is popped.
- R4: The destination byte address is bits 23:0 of tag word 0. Bits 27:24 of word 0 have no effect on the address.
- R5: The payload length is bits 23:0 of tag word 1. Its upper byte and tag words 2 and 3 have no effect.
- R6: Each payload word is popped and written on the same cycle, with `memData` equal to the popped word. The first write of a payload goes to the tag's address, and each later write is 4 bytes higher. At most one word moves per cycle.
- R7: The chain stops after a tag's payload if bit 31 (interrupt request) or bit 30 (the top bit of the 3-bit ID in bits 30:28) of word 0 is set. IDs 1, 2 and 3 without bit 31 make the block read a further tag.
- R8: A tag with a length of zero produces no write.
- R9: `busy` falls on the cycle after the stop condition is met with nothing left to move. `irq` is then raised for exactly one cycle, N cycles after `busy` falls. N = floor(payload words of the transfer / 4), or 1 if that value is 0.
- R10: `xferFlag` clears on the same edge that raises `irq`.
- R11: If the FIFO runs empty during a payload, writing pauses and `busy` stays high. Writing resumes once words arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a transfer |
| fifoCount | input | OCC_W | Words currently held in the FIFO |
| fifoData | input | 32 | Head word of the FIFO (show-ahead) |
| fifoPop | output | 1 | Removes the head word at the clock edge |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Memory byte address |
| memData | output | 32 | Memory write data |
| busy | output | 1 | Transfer consuming the stream |
| xferFlag | output | 1 | Transfer-in-progress flag, cleared at the interrupt |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The hardest state to reach from the ports is a tag that is waiting with only part of its four words present. A close second is a payload that has stalled on an empty FIFO. The bench feeds the FIFO model from the test tasks, one word at a time. It starts a transfer with three tag words queued and confirms that nothing is popped, then completes the tag. A later scenario withholds half of a payload, sends a stray `start` during the stall, and then supplies the rest. The interrupt delay is checked against the word total over chains that mix terminating and non-terminating IDs with zero-length tags.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  typedef struct packed {
    logic clear;
    logic loadAddr;
    logic loadCount;
    logic move;
    logic finish;
  } dpStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TAG, ST_WAIT} ctrlState_t;
endpackage

// File: rtl/tagDatapath.sv
module tagDatapath import dtr_pkg::*; #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 24,
  parameter int ACC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [31:0]       fifoData,
  output logic [ADDR_W-1:0] addrOut,
  output logic              cntZero,
  output logic              endFlag,
  output logic [ACC_W-1:0]  irqDelay
);
  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  cntQ;
  logic [ACC_W-1:0]  wordsQ;
  logic              endQ;
  logic [ACC_W-1:0]  quarter;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      cntQ   <= '0;
      wordsQ <= '0;
      endQ   <= 1'b0;
    end else begin
      if (stb.clear) begin
        cntQ   <= '0;
        wordsQ <= '0;
        endQ   <= 1'b0;
      end
      if (stb.loadAddr) begin
        addrQ <= fifoData[ADDR_W-1:0];
        endQ  <= fifoData[31] | fifoData[30];
      end
      if (stb.loadCount) cntQ <= fifoData[CNT_W-1:0];
      if (stb.move) begin
        addrQ  <= addrQ + ADDR_W'(4);
        cntQ   <= cntQ - CNT_W'(1);
        wordsQ <= wordsQ + ACC_W'(1);
      end
      if (stb.finish) endQ <= 1'b0;
    end
  end

  assign quarter  = wordsQ >> 2;
  assign irqDelay = (quarter == '0) ? ACC_W'(1) : quarter;
  assign addrOut  = addrQ;
  assign cntZero  = (cntQ == '0);
  assign endFlag  = endQ;
endmodule

// File: rtl/tagCtrl.sv
module tagCtrl import dtr_pkg::*; #(
  parameter int OCC_W = 8,
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [OCC_W-1:0] fifoCount,
  input  logic             cntZero,
  input  logic             endFlag,
  input  logic [ACC_W-1:0] irqDelay,
  output dpStrobe_t        stb,
  output logic             fifoPop,
  output logic             busy,
  output logic             xferFlag,
  output logic             irq
);
  localparam int TAG_WORDS = 4;
  localparam int PH_W = $clog2(TAG_WORDS);

  ctrlState_t       state;
  logic [PH_W-1:0]  phase;
  logic [ACC_W-1:0] delay;

  always_comb begin
    stb     = '0;
    fifoPop = 1'b0;
    case (state)
      ST_IDLE: stb.clear = start;
      ST_RUN: begin
        if (cntZero && endFlag) begin
          stb.finish = 1'b1;
        end else if (cntZero && fifoCount >= OCC_W'(TAG_WORDS)) begin
          stb.loadAddr = 1'b1;
          fifoPop      = 1'b1;
        end else if (!cntZero && fifoCount != '0) begin
          stb.move = 1'b1;
          fifoPop  = 1'b1;
        end
      end
      ST_TAG: begin
        fifoPop       = 1'b1;
        stb.loadCount = (phase == PH_W'(1));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= '0;
      delay    <= '0;
      busy     <= 1'b0;
      xferFlag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_RUN;
          busy     <= 1'b1;
          xferFlag <= 1'b1;
        end
        ST_RUN: begin
          if (stb.finish) begin
            state <= ST_WAIT;
            busy  <= 1'b0;
            delay <= irqDelay;
          end else if (stb.loadAddr) begin
            state <= ST_TAG;
            phase <= PH_W'(1);
          end
        end
        ST_TAG: begin
          phase <= phase + PH_W'(1);
          if (phase == PH_W'(TAG_WORDS - 1)) state <= ST_RUN;
        end
        ST_WAIT: begin
          if (delay == ACC_W'(1)) begin
            irq      <= 1'b1;
            xferFlag <= 1'b0;
            state    <= ST_IDLE;
          end else begin
            delay <= delay - ACC_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmaTagReader.sv
module dmaTagReader import dtr_pkg::*; #(
  parameter int OCC_W  = 8,
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 24,
  parameter int ACC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [OCC_W-1:0]  fifoCount,
  input  logic [31:0]       fifoData,
  output logic              fifoPop,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memData,
  output logic              busy,
  output logic              xferFlag,
  output logic              irq
);
  dpStrobe_t        stb;
  logic             cntZero;
  logic             endFlag;
  logic [ACC_W-1:0] irqDelay;

  tagCtrl #(.OCC_W(OCC_W), .ACC_W(ACC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .fifoCount(fifoCount),
    .cntZero(cntZero), .endFlag(endFlag), .irqDelay(irqDelay),
    .stb(stb), .fifoPop(fifoPop), .busy(busy), .xferFlag(xferFlag), .irq(irq)
  );

  tagDatapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .fifoData(fifoData),
    .addrOut(memAddr), .cntZero(cntZero), .endFlag(endFlag), .irqDelay(irqDelay)
  );

  assign memWe   = stb.move;
  assign memData = fifoData;
endmodule

// File: rtl/tagReaderChecker.sv
module tagReaderChecker #(
  parameter int OCC_W  = 8,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [OCC_W-1:0]  fifoCount,
  input logic [31:0]       fifoData,
  input logic              fifoPop,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memData,
  input logic              busy,
  input logic              xferFlag,
  input logic              irq
);
  assert_pop_has_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> fifoCount != '0);
  assert_idle_no_pop_R3: assert property (@(posedge clk) disable iff (!rstN)
    !xferFlag |-> !fifoPop);
  assert_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !xferFlag) |=> (busy && xferFlag));
  assert_write_pops_R6: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (fifoPop && busy && memData == fifoData));
  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> memAddr == $past(memAddr) + ADDR_W'(4));
  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
  assert_irq_not_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !busy);
  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $fell(xferFlag));
endmodule

bind dmaTagReader tagReaderChecker #(.OCC_W(OCC_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_dmaTagReader.sv
module test_dmaTagReader;
  localparam int OCC_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [OCC_W-1:0] fifoCount;
  logic [31:0] fifoData;
  logic fifoPop, memWe, busy, xferFlag, irq;
  logic [23:0] memAddr;
  logic [31:0] memData;

  always #5 clk = ~clk;

  dmaTagReader i_dmaTagReader (
    .clk(clk), .rstN(rstN), .start(start), .fifoCount(fifoCount), .fifoData(fifoData),
    .fifoPop(fifoPop), .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .busy(busy), .xferFlag(xferFlag), .irq(irq)
  );

  // FIFO model
  logic [31:0] fmem [0:1023];
  int wp = 0;
  int rp = 0;
  assign fifoCount = OCC_W'(wp - rp);
  assign fifoData  = fmem[rp[9:0]];
  always @(posedge clk) if (fifoPop) rp <= rp + 1;

  // monitor
  int cyc = 0;
  int nW = 0, nPop = 0, nIrq = 0, busyFall = 0, irqAt = 0;
  bit irqWide = 0, prevBusy = 0, prevIrq = 0;
  logic [23:0] wAddr [0:63];
  logic [31:0] wData [0:63];
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (memWe) begin wAddr[nW[5:0]] = memAddr; wData[nW[5:0]] = memData; nW++; end
    if (fifoPop) nPop++;
    if (prevBusy && !busy) busyFall = cyc;
    if (irq) begin nIrq++; irqAt = cyc; end
    if (irq && prevIrq) irqWide = 1;
    prevBusy = busy;
    prevIrq = irq;
  end

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    fmem[wp[9:0]] = w;
    wp++;
  endtask

  task automatic pushTag(input logic [23:0] a, input logic [23:0] n, input logic [2:0] id, input bit rq);
    push({rq, id, 4'hA, a});
    push({8'hEE, n});
    push(32'hDEAD0002);
    push(32'hDEAD0003);
  endtask

  task automatic clearMon();
    @(negedge clk);
    nW = 0; nPop = 0; nIrq = 0; irqWide = 0;
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitIrq();
    int t = 0;
    while (nIrq == 0 && t < 3000) begin @(negedge clk); t++; end
    @(negedge clk);
  endtask

  function automatic int expDelay(input int words);
    return (words / 4 == 0) ? 1 : words / 4;
  endfunction

  task automatic checkEnd(input string tag, input int words);
    chk(nIrq == 1 && !irqWide, "R9 irq single pulse", nIrq, 1);
    chk(irqAt - busyFall == expDelay(words), {"R9 irq delay ", tag}, irqAt - busyFall, expDelay(words));
    chk(!xferFlag && !busy, "R10 flag cleared", xferFlag, 0);
  endtask

  task automatic testReset();
    chk(!busy && !xferFlag && !irq && !memWe && !fifoPop, "R1 reset outputs",
        {busy, xferFlag, irq, memWe, fifoPop}, 0);
  endtask

  task automatic testSingle();
    clearMon();
    pushTag(24'h123450, 24'd3, 3'd0, 1'b1);
    for (int i = 0; i < 3; i++) push(32'hC0DE0000 + i);
    pulseStart();
    chk(busy && xferFlag, "R2 start raises busy", {busy, xferFlag}, 3);
    waitIrq();
    chk(nW == 3, "R6 write count", nW, 3);
    chk(wAddr[0] == 24'h123450, "R4 address low 24 bits", wAddr[0], 24'h123450);
    chk(wAddr[2] == 24'h123458 && wData[2] == 32'hC0DE0002, "R6 address step and data", wAddr[2], 24'h123458);
    chk(nPop == 7, "R5 tag words 2,3 discarded, 4 plus 3 pops", nPop, 7);
    checkEnd("single", 3);
  endtask

  task automatic testChain();
    clearMon();
    pushTag(24'h000100, 24'd2, 3'd0, 1'b0);
    push(32'h11); push(32'h22);
    pushTag(24'h000200, 24'd8, 3'd4, 1'b0);
    for (int i = 0; i < 8; i++) push(32'h300 + i);
    pulseStart();
    waitIrq();
    chk(nW == 10, "R7 chained tags both serviced", nW, 10);
    chk(wAddr[1] == 24'h104 && wAddr[2] == 24'h200, "R4 second tag address", wAddr[2], 24'h200);
    chk(wData[9] == 32'h307, "R6 last data", wData[9], 32'h307);
    checkEnd("chain", 10);
  endtask

  task automatic testIdZero();
    clearMon();
    pushTag(24'h000400, 24'd1, 3'd3, 1'b0);
    push(32'h55);
    pushTag(24'h000800, 24'd0, 3'd4, 1'b0);
    pulseStart();
    waitIrq();
    chk(nW == 1 && wAddr[0] == 24'h400, "R7 ID 3 continues, R8 zero length no write", nW, 1);
    chk(nPop == 9, "R3 two tags popped", nPop, 9);
    checkEnd("zero", 1);
  endtask

  task automatic testPartialTag();
    clearMon();
    push({1'b1, 3'd0, 4'h0, 24'h000A00});
    push({8'h00, 24'd16}); push(32'h0);
    pulseStart();
    repeat (10) @(negedge clk);
    chk(nPop == 0 && fifoCount == 3, "R3 no pop with 3 tag words", nPop, 0);
    push(32'h0);
    for (int i = 0; i < 16; i++) push(32'h900 + i);
    waitIrq();
    chk(nW == 16 && wAddr[15] == 24'hA3C, "R6 long payload", wAddr[15], 24'hA3C);
    checkEnd("long", 16);
  endtask

  task automatic testStall();
    clearMon();
    pushTag(24'h000C00, 24'd4, 3'd0, 1'b1);
    push(32'hA0); push(32'hA1);
    pulseStart();
    repeat (12) @(negedge clk);
    chk(nW == 2 && busy, "R11 stall keeps busy", nW, 2);
    pulseStart();
    repeat (3) @(negedge clk);
    chk(nW == 2 && busy && nIrq == 0, "R2 start while busy ignored", nW, 2);
    push(32'hA2); push(32'hA3);
    waitIrq();
    chk(nW == 4 && wAddr[3] == 24'hC0C && wData[3] == 32'hA3, "R11 resume after stall", wAddr[3], 24'hC0C);
    checkEnd("stall", 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testSingle();
    testChain();
    testIdZero();
    testPartialTag();
    testStall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule